// File: doc/BRIEF.md
# Banked Wide-Issue Register File

This block holds the architectural registers of a four-slot wide-issue datapath. The 64 registers are split into four banks of sixteen. Each issue slot owns exactly one bank. That bank's single write port belongs to the slot, so four independent results, one per bank, can retire in the same clock. A register is named by a 6-bit index. Its top two bits select the bank and its low four bits select the entry inside that bank.

Each slot reads two source operands. The first operand always comes from the slot's own bank and is addressed by a 4-bit local index. The second operand uses a full 6-bit index and may name any register. When it names a register in a different bank, the request goes through a small crossbar. Each bank offers a limited number of spare read ports (parameter `XPORTS`) to that crossbar. Requests beyond that number are scheduling conflicts. They are reported per slot and return zero.

Reads are combinational and writes take effect at the clock edge. A parameter (`BYPASS`) chooses whether a read of a register being written in the same cycle sees the old contents or the incoming data.

Top module: `vrf_banked`

## Requirements
- R1: After reset, every one of the 64 registers reads as zero.
- R2: Bits [5:4] of a 6-bit register index give the bank and bits [3:0] give the entry. A write from slot s with enable high and bank field equal to s stores its data into that register at the clock edge.
- R3: All four slots can write their own banks in the same cycle, and all four values are stored.
- R4: Operand A of slot s returns the register at entry rdAddrA[s] of bank s.
- R5: Operand B of slot s returns the addressed register when bits [5:4] of rdAddrB[s] equal s. Such a read never raises a conflict.
- R6: Each bank serves at most `XPORTS` operand-B reads per cycle from other slots (default 1), and lower-numbered slots are served first. A slot that is not served gets zero on rdDataB and a high bit in conflict for that cycle.
- R7: A write whose bank field differs from the writing slot number changes no register, and it raises wrErr for that slot in the same cycle.
- R8: With `BYPASS`=0, a read of a register being written in the same cycle returns the value held before the write.
- R9: With `BYPASS`=1, a read of a register being written in the same cycle returns the incoming write data.
- R10: A slot with wrEn low changes no register and raises no wrErr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset, clears all registers |
| wrEn | input | 4 | Per-slot write enable |
| wrAddr | input | 4x6 | Per-slot write register index |
| wrData | input | 4xDATA_W | Per-slot write data |
| rdAddrA | input | 4x4 | Per-slot operand A entry within the slot's own bank |
| rdAddrB | input | 4x6 | Per-slot operand B register index, any bank |
| rdDataA | output | 4xDATA_W | Per-slot operand A data |
| rdDataB | output | 4xDATA_W | Per-slot operand B data, zero when the slot is not served |
| wrErr | output | 4 | Per-slot flag for a write aimed at a foreign bank |
| conflict | output | 4 | Per-slot flag for a cross-bank read that was not served |

## Verification
The hardest case to reach from the ports is a cross-bank read that lands on the same register another slot is writing in that cycle, while a third slot competes for the same bank's crossbar port. Uniform random indices almost never line up this way. The stimulus therefore draws local entries from a narrow range most of the time, and it draws operand-B banks from only four choices so that collisions on one bank happen often. Directed cycles then pin down the three-way contention on one bank and the foreign-bank write. Two instances, one with and one without bypass, receive identical stimulus so that the old-value and new-value rules are compared on the same accesses.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  localparam int BANKS     = 4;
  localparam int BANK_REGS = 16;
  localparam int BANK_W    = $clog2(BANKS);
  localparam int LOC_W     = $clog2(BANK_REGS);
  localparam int IDX_W     = BANK_W + LOC_W;

  // strobes from decode/arbitration into the storage datapath
  typedef struct packed {
    logic [BANKS-1:0]             wrStb;
    logic [BANKS-1:0][LOC_W-1:0]  wrLoc;
    logic [BANKS-1:0][BANK_W-1:0] bBank;
    logic [BANKS-1:0][LOC_W-1:0]  bLoc;
    logic [BANKS-1:0]             bValid;
  } vrf_ctl_t;
endpackage

// File: rtl/vrf_ctrl.sv
module vrf_ctrl
  import vrf_pkg::*;
#(
  parameter int XPORTS = 1
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [BANKS-1:0]                wrEn,
  input  logic [BANKS-1:0][IDX_W-1:0]     wrAddr,
  input  logic [BANKS-1:0][IDX_W-1:0]     rdAddrB,
  output vrf_ctl_t                        ctl,
  output logic [BANKS-1:0]                wrErr,
  output logic [BANKS-1:0]                conflict
);
  logic [BANKS-1:0][BANKS-1:0] grantMap;   // [bank][slot]

  always_comb begin : decodeArb
    int cnt;
    ctl      = '0;
    wrErr    = '0;
    conflict = '0;
    grantMap = '0;
    for (int s = 0; s < BANKS; s++) begin
      ctl.wrLoc[s] = wrAddr[s][LOC_W-1:0];
      ctl.bBank[s] = rdAddrB[s][IDX_W-1:LOC_W];
      ctl.bLoc[s]  = rdAddrB[s][LOC_W-1:0];
      if (wrAddr[s][IDX_W-1:LOC_W] == BANK_W'(s)) ctl.wrStb[s] = wrEn[s];
      else                                        wrErr[s]     = wrEn[s];
    end
    // per bank: cross-bank requesters in slot order, lowest first
    for (int b = 0; b < BANKS; b++) begin
      cnt = 0;
      for (int s = 0; s < BANKS; s++) begin
        if (s != b && rdAddrB[s][IDX_W-1:LOC_W] == BANK_W'(b)) begin
          if (cnt < XPORTS) grantMap[b][s] = 1'b1;
          else              conflict[s]    = 1'b1;
          cnt++;
        end
      end
    end
    ctl.bValid = ~conflict;
  end

  generate
    for (genvar b = 0; b < BANKS; b++) begin : gChk
      p_port_cap_r6: assert property (@(posedge clk) disable iff (!rstN)
        $countones(grantMap[b]) <= XPORTS);
      p_own_never_granted_r5: assert property (@(posedge clk) disable iff (!rstN)
        grantMap[b][b] == 1'b0);
      p_err_blocks_write_r7: assert property (@(posedge clk) disable iff (!rstN)
        wrErr[b] |-> !ctl.wrStb[b]);
    end
  endgenerate
endmodule

// File: rtl/vrf_datapath.sv
module vrf_datapath
  import vrf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter bit BYPASS = 1'b0
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  vrf_ctl_t                        ctl,
  input  logic [BANKS-1:0][DATA_W-1:0]    wrData,
  input  logic [BANKS-1:0][LOC_W-1:0]     rdAddrA,
  output logic [BANKS-1:0][DATA_W-1:0]    rdDataA,
  output logic [BANKS-1:0][DATA_W-1:0]    rdDataB
);
  logic [BANKS-1:0][BANK_REGS-1:0][DATA_W-1:0] regs;

  generate
    for (genvar b = 0; b < BANKS; b++) begin : gBank
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              regs[b] <= '0;
        else if (ctl.wrStb[b])  regs[b][ctl.wrLoc[b]] <= wrData[b];
      end

      p_write_lands_r2: assert property (@(posedge clk) disable iff (!rstN)
        ctl.wrStb[b] |=> regs[b][$past(ctl.wrLoc[b])] == $past(wrData[b]));
      p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
        !ctl.wrStb[b] |=> $stable(regs[b]));
    end

    for (genvar s = 0; s < BANKS; s++) begin : gSlot
      logic [BANK_W-1:0] srcBank;
      logic              hitA, hitB;
      assign srcBank = ctl.bBank[s];
      assign hitA = BYPASS && ctl.wrStb[s] && ctl.wrLoc[s] == rdAddrA[s];
      assign hitB = BYPASS && ctl.wrStb[srcBank] && ctl.wrLoc[srcBank] == ctl.bLoc[s];

      always_comb begin
        rdDataA[s] = hitA ? wrData[s] : regs[s][rdAddrA[s]];
        if (!ctl.bValid[s]) rdDataB[s] = '0;
        else if (hitB)      rdDataB[s] = wrData[srcBank];
        else                rdDataB[s] = regs[srcBank][ctl.bLoc[s]];
      end
    end
  endgenerate
endmodule

// File: rtl/vrf_banked.sv
module vrf_banked
  import vrf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int XPORTS = 1,
  parameter bit BYPASS = 1'b0
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [BANKS-1:0]                wrEn,
  input  logic [BANKS-1:0][IDX_W-1:0]     wrAddr,
  input  logic [BANKS-1:0][DATA_W-1:0]    wrData,
  input  logic [BANKS-1:0][LOC_W-1:0]     rdAddrA,
  input  logic [BANKS-1:0][IDX_W-1:0]     rdAddrB,
  output logic [BANKS-1:0][DATA_W-1:0]    rdDataA,
  output logic [BANKS-1:0][DATA_W-1:0]    rdDataB,
  output logic [BANKS-1:0]                wrErr,
  output logic [BANKS-1:0]                conflict
);
  vrf_ctl_t ctl;

  vrf_ctrl #(.XPORTS(XPORTS)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .rdAddrB(rdAddrB), .ctl(ctl), .wrErr(wrErr), .conflict(conflict)
  );

  vrf_datapath #(.DATA_W(DATA_W), .BYPASS(BYPASS)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdDataB(rdDataB)
  );

  generate
    for (genvar s = 0; s < BANKS; s++) begin : gTop
      p_denied_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
        conflict[s] |-> rdDataB[s] == '0);
      p_own_no_conflict_r5: assert property (@(posedge clk) disable iff (!rstN)
        rdAddrB[s][IDX_W-1:LOC_W] == BANK_W'(s) |-> !conflict[s]);
    end
  endgenerate
endmodule

// File: tb/tb_vrf_banked.sv
`timescale 1ns/1ps
module tb_vrf_banked;
  localparam int XP = 1;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0]        wrEn;
  logic [3:0][5:0]   wrAddr;
  logic [3:0][31:0]  wrData;
  logic [3:0][3:0]   rdA;
  logic [3:0][5:0]   rdB;
  logic [3:0][31:0]  dA, dB, pA, pB;
  logic [3:0]        wrErr, conflict, wrErrP, conflictP;

  vrf_banked #(.DATA_W(32), .XPORTS(XP), .BYPASS(1'b0)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddrA(rdA), .rdAddrB(rdB), .rdDataA(dA), .rdDataB(dB),
    .wrErr(wrErr), .conflict(conflict));

  vrf_banked #(.DATA_W(32), .XPORTS(XP), .BYPASS(1'b1)) dutByp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddrA(rdA), .rdAddrB(rdB), .rdDataA(pA), .rdDataB(pB),
    .wrErr(wrErrP), .conflict(conflictP));

  logic [31:0] model [64];
  int total = 0;
  int bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit legalWr(int w);
    return wrEn[w] && (wrAddr[w][5:4] == 2'(w));
  endfunction

  function automatic bit wrHit(logic [5:0] addr);
    for (int w = 0; w < 4; w++) if (legalWr(w) && wrAddr[w] == addr) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] wrVal(logic [5:0] addr);
    for (int w = 0; w < 4; w++) if (legalWr(w) && wrAddr[w] == addr) return wrData[w];
    return 32'h0;
  endfunction

  // inputs already driven; check in mid-cycle, then clock and update model
  task automatic evalCycle();
    int cnt [4];
    logic [3:0] expDeny;
    logic [5:0] a;
    logic [31:0] e;
    #1;
    expDeny = '0;
    for (int b = 0; b < 4; b++) cnt[b] = 0;
    for (int s = 0; s < 4; s++) begin
      if (rdB[s][5:4] != 2'(s)) begin
        if (cnt[rdB[s][5:4]] >= XP) expDeny[s] = 1'b1;
        cnt[rdB[s][5:4]]++;
      end
    end
    for (int s = 0; s < 4; s++) begin
      chk("R7/R10 wrErr", {31'b0, wrErr[s]}, {31'b0, wrEn[s] && wrAddr[s][5:4] != 2'(s)});
      chk("R6 conflict", {31'b0, conflict[s]}, {31'b0, expDeny[s]});
      chk("R6 conflict byp", {31'b0, conflictP[s]}, {31'b0, expDeny[s]});
      a = {2'(s), rdA[s]};
      e = model[a];
      chk(wrHit(a) ? "R8 rdA" : "R4 rdA", dA[s], e);
      chk("R9 rdA byp", pA[s], wrHit(a) ? wrVal(a) : e);
      a = rdB[s];
      e = expDeny[s] ? 32'h0 : model[a];
      chk(a[5:4] == 2'(s) ? (wrHit(a) ? "R8 rdB own" : "R5 rdB own") : "R6 rdB cross", dB[s], e);
      chk("R9 rdB byp", pB[s], (!expDeny[s] && wrHit(a)) ? wrVal(a) : e);
    end
    @(posedge clk);
    for (int w = 0; w < 4; w++) if (legalWr(w)) model[wrAddr[w]] = wrData[w];
    #1;
  endtask

  task automatic idleInputs();
    wrEn = '0;
    for (int s = 0; s < 4; s++) begin
      wrAddr[s] = {2'(s), 4'h0}; wrData[s] = '0;
      rdA[s] = '0; rdB[s] = {2'(s), 4'h0};
    end
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=done");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) model[i] = '0;
    idleInputs();
    #12;
    @(posedge clk); #1;
    rstN = 1'b1;

    // R1: all registers zero after reset, read through operand A
    for (int i = 0; i < 16; i++) begin
      for (int s = 0; s < 4; s++) rdA[s] = 4'(i);
      #1;
      for (int s = 0; s < 4; s++) chk("R1 reset value", dA[s], 32'h0);
      @(posedge clk); #1;
    end

    // R3/R2: four slots retire into r0, r16, r32, r48 together
    for (int s = 0; s < 4; s++) begin
      wrEn[s] = 1'b1; wrAddr[s] = {2'(s), 4'h0}; wrData[s] = 32'hA000_0000 + 32'(s);
    end
    evalCycle();
    idleInputs();
    #1;
    for (int s = 0; s < 4; s++) chk("R3 parallel retire", dA[s], 32'hA000_0000 + 32'(s));
    evalCycle();

    // R2: slot 2 writes index 37 (bank 2, entry 5); slot 0 reads it cross-bank
    wrEn[2] = 1'b1; wrAddr[2] = 6'd37; wrData[2] = 32'h0000_5EED;
    evalCycle();
    idleInputs();
    rdB[0] = 6'd37;
    #1;
    chk("R2 bank decode", dB[0], 32'h0000_5EED);
    evalCycle();

    // R6: slots 0,1,2 all want bank 3; only slot 0 served
    for (int s = 0; s < 3; s++) rdB[s] = 6'd48;
    rdB[3] = 6'd49;
    #1;
    chk("R6 lowest slot first", {28'b0, conflict}, 32'h6);
    chk("R6 winner data", dB[0], 32'hA000_0003);
    evalCycle();
    idleInputs();

    // R7: slot 1 aims at bank 0 index 5; ignored and flagged
    wrEn[1] = 1'b1; wrAddr[1] = 6'd5; wrData[1] = 32'hDEAD_BEEF;
    #1;
    chk("R7 foreign write flag", {31'b0, wrErr[1]}, 32'h1);
    evalCycle();
    idleInputs();
    rdA[0] = 4'd5;
    #1;
    chk("R7 foreign write ignored", dA[0], 32'h0);
    evalCycle();

    // R8/R9: same-cycle write and read of r20 from slot 1
    wrEn[1] = 1'b1; wrAddr[1] = 6'd20; wrData[1] = 32'h1234_5678;
    rdA[1] = 4'd4; rdB[0] = 6'd20;
    #1;
    chk("R8 old value", dA[1], 32'h0);
    chk("R9 new value", pA[1], 32'h1234_5678);
    chk("R9 new value cross", pB[0], 32'h1234_5678);
    evalCycle();

    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      for (int s = 0; s < 4; s++) begin
        wrEn[s]   = ($urandom % 4) != 0;
        wrAddr[s] = {(($urandom % 8) == 0) ? 2'($urandom) : 2'(s),
                     (($urandom % 4) == 0) ? 4'($urandom) : 4'($urandom % 4)};
        wrData[s] = $urandom;
        rdA[s]    = (($urandom % 4) == 0) ? 4'($urandom) : 4'($urandom % 4);
        rdB[s]    = {2'($urandom), (($urandom % 4) == 0) ? 4'($urandom) : 4'($urandom % 4)};
      end
      evalCycle();
    end

    finishRun();
  end
endmodule